// File: doc/BRIEF.md
# Stallable Pipelined Register File

This block is the integer register file of a small in-order pipeline: 32 words of 32 bits, two read ports and one write port. The decode stage presents two source register numbers each cycle. The block captures the two operands in output registers, so they reach the execute stage one clock later, in step with the decode stage's own payload. The writeback stage updates one destination register per clock through the write port.

A read-enable input is driven from the inverse of the decode stall. While it is low, both operand registers keep their values, so the file stalls together with decode. Writes are not gated by the stall. Register 0 is the constant-zero register: it always reads as zero, and writes to it are dropped. A write and a read of the same nonzero register in the same cycle return the data being written. No flush input exists, because the file carries no instruction state.

Top module: `gpr_bank`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`, and a later read of that register returns it. Each of the 32 registers holds 32 bits independently of the others.
- R2: A read of address 0 returns zero on either port, even after writes to address 0 have been attempted.
- R3: The two read ports use `rs1_addr` and `rs2_addr` independently and in the same cycle. Each port's output reflects only its own address.
- R4: A write is dropped when `wr_en` is low or when `wr_addr` is 0. The stored contents are then unchanged, as later reads show.
- R5: Read data appears on `rs1_data` and `rs2_data` one clock edge after the address is sampled with `rd_en` high.
- R6: While `rd_en` is low, both `rs1_data` and `rs2_data` keep their previous values.
- R7: When `rd_en` and `wr_en` are high and `wr_addr` equals a nonzero read address in the same cycle, that port captures `wr_data` (write-first).
- R8: A synchronous active-high `rst` clears both read outputs and all stored registers to zero.
- R9: Writes take effect while `rd_en` is low. After the stall ends, a read returns the value written during the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read enable (inverse of decode stall); low holds both outputs |
| rs1_addr | input | 5 | First source register number |
| rs2_addr | input | 5 | Second source register number |
| wr_en | input | 1 | Write enable from writeback |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Data to write |
| rs1_data | output | 32 | Registered first operand |
| rs2_data | output | 32 | Registered second operand |

## Verification
The bench builds the block with its default values of 32 registers and 32 data bits. At that size every address, including the zero register and the top entry 31, can be written and read back against a 32-word reference model. Full-width data patterns reach every bit of every word. The two-port default also lets a single cycle combine a forwarded read on one port with a plain or zero read on the other.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
    localparam int DEF_NUM_REGS   = 32;
    localparam int DEF_DATA_W     = 32;
    localparam int NUM_READ_PORTS = 2;
endpackage

// File: rtl/gpr_bank_store.sv
module gpr_bank_store #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_addr [NUM_RD],
    output logic [DATA_W-1:0]           rd_word [NUM_RD]
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    // Register 0 is never written, so it keeps the zero loaded by reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en && (wr_addr != '0)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_word[g] = mem[rd_addr[g]];
    end

    // R1: an accepted write lands in the addressed word
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr != '0)) |=> (mem[$past(wr_addr)] == $past(wr_data)));

    // R4: an attempted write to register 0 leaves it at zero
    a_r4_zero_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == '0)) |=> (mem[0] == '0));
endmodule

// File: rtl/gpr_bank_rdport.sv
module gpr_bank_rdport #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_word,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    logic              fwd_hit;
    logic [DATA_W-1:0] next_q;

    always_comb begin
        fwd_hit = wr_en && (wr_addr == addr) && (addr != '0);
        if (addr == '0) begin
            next_q = '0;
        end else if (fwd_hit) begin
            next_q = wr_data;
        end else begin
            next_q = mem_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (rd_en) begin
            q <= next_q;
        end
    end

    // R2: register 0 reads as zero
    a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == '0)) |=> (q == '0));

    // R6: outputs hold while reads are disabled
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(q));

    // R7: same-cycle write to the read address is forwarded
    a_r7_forward: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && (wr_addr == addr) && (addr != '0)) |=> (q == $past(wr_data)));

    // R8: reset clears the output register
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_bank_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DATA_W   = DEF_DATA_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [$clog2(NUM_REGS)-1:0] rs1_addr,
    input  logic [$clog2(NUM_REGS)-1:0] rs2_addr,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [DATA_W-1:0]           rs1_data,
    output logic [DATA_W-1:0]           rs2_data
);
    localparam int ADDR_W = $clog2(NUM_REGS);

    logic [ADDR_W-1:0] port_addr [NUM_READ_PORTS];
    logic [DATA_W-1:0] port_word [NUM_READ_PORTS];
    logic [DATA_W-1:0] port_q    [NUM_READ_PORTS];

    assign port_addr[0] = rs1_addr;
    assign port_addr[1] = rs2_addr;
    assign rs1_data     = port_q[0];
    assign rs2_data     = port_q[1];

    gpr_bank_store #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .NUM_RD   (NUM_READ_PORTS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (port_addr),
        .rd_word (port_word)
    );

    for (genvar p = 0; p < NUM_READ_PORTS; p++) begin : g_port
        gpr_bank_rdport #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_rdport (
            .clk      (clk),
            .rst      (rst),
            .rd_en    (rd_en),
            .addr     (port_addr[p]),
            .mem_word (port_word[p]),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .q        (port_q[p])
        );
    end

    // R9: a write during a stall still reaches storage and is read after it
    a_r9_stall_write: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && wr_en && (wr_addr != '0) && (wr_addr != rs1_addr))
        |=> (rd_en && (rs1_addr == $past(wr_addr)) && !(wr_en && (wr_addr == rs1_addr)))
        |=> (rs1_data == $past(wr_data, 2)));
endmodule

// File: tb/gpr_bank_test.sv
module gpr_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en;
    logic [4:0]  rs1_addr, rs2_addr, wr_addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rs1_data, rs2_data;

    logic [31:0] ref_mem [32];
    logic [31:0] exp1, exp2;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_bank uut (
        .clk(clk), .rst(rst), .rd_en(rd_en),
        .rs1_addr(rs1_addr), .rs2_addr(rs2_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rs1_data(rs1_data), .rs2_data(rs2_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] expect_read(input logic [4:0] a, input logic we,
                                                input logic [4:0] wa, input logic [31:0] wd);
        if (a == 5'd0) return 32'd0;
        if (we && wa == a) return wd;
        return ref_mem[a];
    endfunction

    // One clock: drive at negedge, update the model, compare after the edge.
    task automatic step(input string req, input logic re, input logic [4:0] a1, input logic [4:0] a2,
                        input logic we, input logic [4:0] wa, input logic [31:0] wd);
        @(negedge clk);
        rd_en = re; rs1_addr = a1; rs2_addr = a2;
        wr_en = we; wr_addr = wa; wr_data = wd;
        if (re) begin
            exp1 = expect_read(a1, we, wa, wd);
            exp2 = expect_read(a2, we, wa, wd);
        end
        if (we && wa != 5'd0) ref_mem[wa] = wd;
        @(posedge clk);
        #1;
        check(req, rs1_data, exp1);
        check(req, rs2_data, exp2);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
        rs1_addr = 5'd0; rs2_addr = 5'd0; wr_addr = 5'd0; wr_data = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset rs1", rs1_data, 32'd0);
        check("R8 reset rs2", rs2_data, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) ref_mem[i] = '0;
        exp1 = '0; exp2 = '0;
        step("R8 storage clear", 1'b1, 5'd17, 5'd31, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic t_write_read;
        for (int i = 1; i < 32; i++)
            step("R1 fill", 1'b1, 5'd0, 5'd0, 1'b1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
        for (int i = 1; i < 32; i++)
            step("R1 R5 readback", 1'b1, 5'(i), 5'(32 - i), 1'b0, 5'd0, 32'd0);
        step("R1 all ones", 1'b1, 5'd0, 5'd0, 1'b1, 5'd31, 32'hFFFFFFFF);
        step("R1 all ones read", 1'b1, 5'd31, 5'd30, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic t_zero;
        step("R2 R4 write x0", 1'b1, 5'd3, 5'd4, 1'b1, 5'd0, 32'hDEADBEEF);
        step("R2 read x0", 1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 32'd0);
        step("R2 x0 with write x0", 1'b1, 5'd0, 5'd5, 1'b1, 5'd0, 32'h12345678);
        step("R4 disabled write", 1'b1, 5'd0, 5'd0, 1'b0, 5'd9, 32'hCAFEF00D);
        step("R4 read after disabled", 1'b1, 5'd9, 5'd0, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic t_dual;
        step("R3 distinct", 1'b1, 5'd7, 5'd21, 1'b0, 5'd0, 32'd0);
        step("R3 same reg", 1'b1, 5'd12, 5'd12, 1'b0, 5'd0, 32'd0);
        step("R3 zero and nonzero", 1'b1, 5'd0, 5'd31, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic t_stall;
        step("R6 prime", 1'b1, 5'd10, 5'd11, 1'b0, 5'd0, 32'd0);
        step("R6 hold", 1'b0, 5'd2, 5'd3, 1'b0, 5'd0, 32'd0);
        step("R6 hold zero addr", 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'd0);
        step("R5 resume", 1'b1, 5'd2, 5'd3, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic t_forward;
        step("R7 forward rs1", 1'b1, 5'd6, 5'd8, 1'b1, 5'd6, 32'h0BADC0DE);
        step("R7 forward both", 1'b1, 5'd14, 5'd14, 1'b1, 5'd14, 32'h55AA55AA);
        step("R7 no forward to x0", 1'b1, 5'd0, 5'd14, 1'b1, 5'd0, 32'h77777777);
    endtask

    task automatic t_stall_write;
        step("R6 R9 prime", 1'b1, 5'd20, 5'd22, 1'b0, 5'd0, 32'd0);
        step("R9 write in stall", 1'b0, 5'd20, 5'd22, 1'b1, 5'd20, 32'h13579BDF);
        step("R9 write in stall 2", 1'b0, 5'd20, 5'd22, 1'b1, 5'd22, 32'h2468ACE0);
        step("R9 read after stall", 1'b1, 5'd20, 5'd22, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 400; n++)
            step("R1 R3 R6 R7 random", ($urandom % 4) != 0, 5'($urandom), 5'($urandom),
                 ($urandom % 2) != 0, 5'($urandom), $urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp1 = '0; exp2 = '0;
        t_reset();
        t_write_read();
        t_zero();
        t_dual();
        t_stall();
        t_forward();
        t_stall_write();
        t_random();
        t_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule